// File: doc/BRIEF.md
# LCD Vertical Timing Generator

This block sequences the rows of one raster LCD frame. A horizontal timing block hands it a single-cycle strobe at the end of every line period. The block counts those strobes and splits each frame into four regions, in this order: vertical sync, back porch, active rows and front porch. The counter then wraps and the next frame begins.

Two register fields set the frame shape. A 6-bit sync field holds the sync width in line periods, minus one. A 10-bit row field holds the active row count, minus one. Both porches are fixed by parameters. The block latches the fields, together with a dual-panel flag, only when a new frame begins. A frame is therefore never built from a mix of old and new settings.

In dual-panel mode the row field gives the height of each half of the screen. The upper half and the lower half are scanned in the same line period. Alongside the upper-half row index, the block reports the matching lower-half row.

Top module: `lcd_vtiming`

## Requirements
- R1: While reset is applied and just after it, vsync is 1, active is 0, row_idx is 0, lower_row is 0 and sof is 0.
- R2: vsync is 1 for the first (S+1) line periods of each frame, where S is the latched sync field (0..63).
- R3: active is 1 for exactly (L+1) line periods, where L is the latched row field. These periods begin VBP lines after sync ends, and active is never 1 while vsync is 1.
- R4: During the k-th active line (k counted from 0), row_idx equals k, which runs 0..L. Outside active lines, row_idx is 0.
- R5: A frame lasts S+1+VBP+L+1+VFP line periods. The line count returns to 0 on the strobe that ends the frame. sof is 1 for exactly the one clock cycle that follows that strobe.
- R6: The frame position changes only on a clock edge where line_stb is 1. With no strobe, all outputs hold.
- R7: Writes to cfg_sync_w, cfg_lines and cfg_dual have no effect on the frame in progress. The values present at the strobe that ends a frame govern the whole next frame.
- R8: When the latched dual flag is 1, lower_row equals row_idx+L+1 during active lines. When the flag is 0, or outside active lines, lower_row is 0. Frame timing is the same in both modes.
- R9: Both latched fields reset to zero. The first frame after reset therefore has one sync line and one active line, and lasts 2+VBP+VFP line periods, whatever the inputs hold.
- R10: With L=1023 a frame has 1024 active lines, and row_idx reaches 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_stb | input | 1 | One-cycle pulse per line period from the horizontal timer |
| cfg_sync_w | input | 6 | Sync width in line periods, minus one |
| cfg_lines | input | 10 | Active rows per panel, minus one |
| cfg_dual | input | 1 | 1 selects dual-panel mode |
| vsync | output | 1 | Vertical sync, high during the sync lines |
| active | output | 1 | High during active rows |
| row_idx | output | 10 | Upper-panel row index, 0 outside active rows |
| lower_row | output | 11 | Lower-panel row in dual mode, else 0 |
| sof | output | 1 | One-cycle start-of-frame pulse |

## Verification
The hardest case to reach is a field change in the middle of a frame. Its effect shows only one frame later, and only if the new value is still in place at the exact strobe that closes the frame. The stimulus changes the fields at chosen lines inside a directed frame and compares the sync, active and frame lengths of that frame and the next one.

Random phases go further. They rewrite the fields at random lines, insert random idle gaps between strobes and follow every line with a model of the latched settings. Strobes in back-to-back cycles are also covered, as is the largest row count.

// File: rtl/lcd_vt_pkg.sv
package lcd_vt_pkg;

  // First line of the active region: sync lines plus back porch.
  function automatic int unsigned vt_act_start(int unsigned sync_m1, int unsigned vbp);
    return sync_m1 + 1 + vbp;
  endfunction

  // Last active line, inclusive.
  function automatic int unsigned vt_act_end(int unsigned sync_m1, int unsigned rows_m1,
                                             int unsigned vbp);
    return vt_act_start(sync_m1, vbp) + rows_m1;
  endfunction

  // Total line periods in one frame.
  function automatic int unsigned vt_frame_len(int unsigned sync_m1, int unsigned rows_m1,
                                               int unsigned vbp, int unsigned vfp);
    return vt_act_end(sync_m1, rows_m1, vbp) + 1 + vfp;
  endfunction

  // Counter width able to hold the longest frame position.
  function automatic int unsigned vt_cnt_width(int unsigned sync_w, int unsigned rows_w,
                                               int unsigned vbp, int unsigned vfp);
    return $clog2((1 << sync_w) + (1 << rows_w) + vbp + vfp + 1);
  endfunction

endpackage

// File: rtl/lcd_vt_shadow.sv
module lcd_vt_shadow #(
  parameter int SYNC_W = 6,
  parameter int ROWS_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SYNC_W-1:0] in_sync,
  input  logic [ROWS_W-1:0] in_rows,
  input  logic              in_dual,
  output logic [SYNC_W-1:0] shd_sync,
  output logic [ROWS_W-1:0] shd_rows,
  output logic              shd_dual
);

  // Settings used by the running frame, refreshed only at a frame boundary.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shd_sync <= '0;
      shd_rows <= '0;
      shd_dual <= 1'b0;
    end else if (load) begin
      shd_sync <= in_sync;
      shd_rows <= in_rows;
      shd_dual <= in_dual;
    end
  end

endmodule

// File: rtl/lcd_vt_counter.sv
module lcd_vt_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_stb,
  input  logic [CNT_W-1:0] last_line,
  output logic [CNT_W-1:0] line_cnt,
  output logic             wrap,
  output logic             sof
);

  assign wrap = line_stb && (line_cnt == last_line);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_cnt <= '0;
      sof      <= 1'b0;
    end else begin
      sof <= wrap;
      if (line_stb) begin
        line_cnt <= wrap ? '0 : line_cnt + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/lcd_vt_decode.sv
module lcd_vt_decode
  import lcd_vt_pkg::*;
#(
  parameter int SYNC_W  = 6,
  parameter int ROWS_W  = 10,
  parameter int CNT_W   = 11,
  parameter int VBP     = 2,
  parameter int VFP     = 3,
  parameter bit DUAL_EN = 1'b1
) (
  input  logic [CNT_W-1:0]  line_cnt,
  input  logic [SYNC_W-1:0] shd_sync,
  input  logic [ROWS_W-1:0] shd_rows,
  input  logic              shd_dual,
  output logic [CNT_W-1:0]  last_line,
  output logic              vsync,
  output logic              active,
  output logic [ROWS_W-1:0] row_idx,
  output logic [ROWS_W:0]   lower_row
);

  logic [CNT_W-1:0] act_start;
  logic [CNT_W-1:0] act_end;
  logic [CNT_W-1:0] row_off;

  always_comb begin
    act_start = CNT_W'(vt_act_start(int'(shd_sync), VBP));
    act_end   = CNT_W'(vt_act_end(int'(shd_sync), int'(shd_rows), VBP));
    last_line = CNT_W'(vt_frame_len(int'(shd_sync), int'(shd_rows), VBP, VFP) - 1);
    vsync     = line_cnt <= CNT_W'(shd_sync);
    active    = (line_cnt >= act_start) && (line_cnt <= act_end);
    row_off   = line_cnt - act_start;
    row_idx   = active ? row_off[ROWS_W-1:0] : '0;
  end

  generate
    if (DUAL_EN) begin : g_dual
      always_comb begin
        if (active && shd_dual) begin
          lower_row = {1'b0, row_idx} + {1'b0, shd_rows} + (ROWS_W+1)'(1);
        end else begin
          lower_row = '0;
        end
      end
    end else begin : g_single
      assign lower_row = '0;
    end
  endgenerate

endmodule

// File: rtl/lcd_vtiming.sv
module lcd_vtiming
  import lcd_vt_pkg::*;
#(
  parameter int SYNC_W  = 6,
  parameter int ROWS_W  = 10,
  parameter int VBP     = 2,
  parameter int VFP     = 3,
  parameter bit DUAL_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_stb,
  input  logic [SYNC_W-1:0] cfg_sync_w,
  input  logic [ROWS_W-1:0] cfg_lines,
  input  logic              cfg_dual,
  output logic              vsync,
  output logic              active,
  output logic [ROWS_W-1:0] row_idx,
  output logic [ROWS_W:0]   lower_row,
  output logic              sof
);

  localparam int CNT_W = vt_cnt_width(SYNC_W, ROWS_W, VBP, VFP);

  // Named internal events, visible to the bound checker.
  logic              wrap;
  logic [CNT_W-1:0]  line_cnt;
  logic [CNT_W-1:0]  last_line;
  logic [SYNC_W-1:0] shd_sync;
  logic [ROWS_W-1:0] shd_rows;
  logic              shd_dual;

  lcd_vt_shadow #(.SYNC_W(SYNC_W), .ROWS_W(ROWS_W)) u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wrap),
    .in_sync  (cfg_sync_w),
    .in_rows  (cfg_lines),
    .in_dual  (cfg_dual),
    .shd_sync (shd_sync),
    .shd_rows (shd_rows),
    .shd_dual (shd_dual)
  );

  lcd_vt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_stb  (line_stb),
    .last_line (last_line),
    .line_cnt  (line_cnt),
    .wrap      (wrap),
    .sof       (sof)
  );

  lcd_vt_decode #(
    .SYNC_W(SYNC_W), .ROWS_W(ROWS_W), .CNT_W(CNT_W),
    .VBP(VBP), .VFP(VFP), .DUAL_EN(DUAL_EN)
  ) u_decode (
    .line_cnt  (line_cnt),
    .shd_sync  (shd_sync),
    .shd_rows  (shd_rows),
    .shd_dual  (shd_dual),
    .last_line (last_line),
    .vsync     (vsync),
    .active    (active),
    .row_idx   (row_idx),
    .lower_row (lower_row)
  );

endmodule

// File: rtl/lcd_vt_chk.sv
module lcd_vt_chk #(
  parameter int ROWS_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_stb,
  input logic              wrap,
  input logic              shd_dual,
  input logic              vsync,
  input logic              active,
  input logic [ROWS_W-1:0] row_idx,
  input logic [ROWS_W:0]   lower_row,
  input logic              sof
);

  p_sof_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> !sof);

  p_wrap_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (vsync && !active && row_idx == '0));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !line_stb |=> ($stable(vsync) && $stable(active) && $stable(row_idx) && $stable(lower_row)));

  p_row_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (row_idx == '0 && lower_row == '0));

  p_sync_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(vsync && active));

  p_sof_in_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sof |-> vsync);

  p_lower_above_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && shd_dual) |-> (lower_row > {1'b0, row_idx}));

endmodule

bind lcd_vtiming lcd_vt_chk #(.ROWS_W(ROWS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .line_stb  (line_stb),
  .wrap      (wrap),
  .shd_dual  (shd_dual),
  .vsync     (vsync),
  .active    (active),
  .row_idx   (row_idx),
  .lower_row (lower_row),
  .sof       (sof)
);

// File: tb/lcd_vtiming_bench.sv
`timescale 1ns/1ps
module lcd_vtiming_bench;

  localparam int VBP = 2;
  localparam int VFP = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_stb = 1'b0;
  logic [5:0] cfg_sync_w = '0;
  logic [9:0] cfg_lines = '0;
  logic       cfg_dual = 1'b0;
  logic       vsync, active, sof;
  logic [9:0] row_idx;
  logic [10:0] lower_row;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Bench model of the frame position and latched settings.
  int pos = 0;
  int m_sync = 0, m_rows = 0, m_dual = 0;
  int max_gap = 0;
  int chg_at = -1, n_sync = 0, n_rows = 0, n_dual = 0;
  int rnd_chg = 0;

  always #2.5 clk = ~clk;

  lcd_vtiming #(.VBP(VBP), .VFP(VFP)) u_lcd_vtiming (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb),
    .cfg_sync_w(cfg_sync_w), .cfg_lines(cfg_lines), .cfg_dual(cfg_dual),
    .vsync(vsync), .active(active), .row_idx(row_idx),
    .lower_row(lower_row), .sof(sof)
  );

  function automatic int f_len(int s, int l);
    return (s + 1) + VBP + (l + 1) + VFP;
  endfunction
  function automatic int f_vs(int p, int s);
    return (p < s + 1) ? 1 : 0;
  endfunction
  function automatic int f_act(int p, int s, int l);
    return (p >= s + 1 + VBP && p < s + 1 + VBP + l + 1) ? 1 : 0;
  endfunction
  function automatic int f_row(int p, int s, int l);
    return f_act(p, s, l) ? p - (s + 1 + VBP) : 0;
  endfunction
  function automatic int f_low(int p, int s, int l, int d);
    return (f_act(p, s, l) && d != 0) ? f_row(p, s, l) + l + 1 : 0;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(int exp_sof);
    chk("R2", "vsync", int'(vsync), f_vs(pos, m_sync));
    chk("R3", "active", int'(active), f_act(pos, m_sync, m_rows));
    chk("R4", "row_idx", int'(row_idx), f_row(pos, m_sync, m_rows));
    chk("R8", "lower_row", int'(lower_row), f_low(pos, m_sync, m_rows, m_dual));
    chk("R5", "sof", int'(sof), exp_sof);
  endtask

  // One line period: idle gap, then a strobe; returns 1 if the frame wrapped.
  task automatic do_line(output int wrapped);
    int gap;
    gap = (max_gap > 0) ? int'($urandom_range(max_gap)) : 0;
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      chk("R6", "hold row_idx", int'(row_idx), f_row(pos, m_sync, m_rows));
      chk("R6", "hold vsync", int'(vsync), f_vs(pos, m_sync));
      chk("R6", "no sof", int'(sof), 0);
    end
    line_stb = 1'b1;
    @(negedge clk);
    line_stb = 1'b0;
    if (pos == f_len(m_sync, m_rows) - 1) begin
      pos = 0;
      m_sync = int'(cfg_sync_w);
      m_rows = int'(cfg_lines);
      m_dual = int'(cfg_dual);
      wrapped = 1;
    end else begin
      pos++;
      wrapped = 0;
    end
    check_all(wrapped);
  endtask

  // Runs from the current frame start until the next one, tallying regions.
  task automatic run_frame(output int n_vs, output int n_act, output int n_tot,
                           output int top_row);
    int w;
    n_vs = int'(vsync);
    n_act = int'(active);
    n_tot = 1;
    top_row = int'(row_idx);
    w = 0;
    while (w == 0) begin
      if (n_tot - 1 == chg_at) begin
        cfg_sync_w = 6'(n_sync);
        cfg_lines = 10'(n_rows);
        cfg_dual = n_dual[0];
      end
      if (rnd_chg != 0 && $urandom_range(15) == 0) begin
        cfg_sync_w = 6'($urandom_range(7));
        cfg_lines = 10'($urandom_range(31));
        cfg_dual = 1'($urandom_range(1));
      end
      do_line(w);
      if (w == 0) begin
        n_tot++;
        n_vs += int'(vsync);
        n_act += int'(active);
        if (int'(row_idx) > top_row) top_row = int'(row_idx);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int vs, ac, tot, top;
    void'($urandom(32'h1c5a_77e1));
    cfg_sync_w = 6'd5;
    cfg_lines = 10'd9;
    cfg_dual = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk("R1", "vsync in reset", int'(vsync), 1);
    chk("R1", "active in reset", int'(active), 0);
    chk("R1", "row in reset", int'(row_idx), 0);
    chk("R1", "sof in reset", int'(sof), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "lower after reset", int'(lower_row), 0);
    chk("R1", "sof after reset", int'(sof), 0);

    // R9: first frame uses zeroed fields
    max_gap = 2;
    run_frame(vs, ac, tot, top);
    chk("R9", "first frame length", tot, 2 + VBP + VFP);
    chk("R9", "first frame sync", vs, 1);
    chk("R9", "first frame active", ac, 1);

    // R7: mid-frame change does not touch the running frame
    chg_at = 7; n_sync = 2; n_rows = 4; n_dual = 1;
    run_frame(vs, ac, tot, top);
    chg_at = -1;
    chk("R7", "old sync kept", vs, 6);
    chk("R7", "old active kept", ac, 10);
    chk("R5", "frame length", tot, f_len(5, 9));
    chk("R4", "top row", top, 9);
    cfg_sync_w = 6'd63;
    cfg_lines = 10'd1023;
    cfg_dual = 1'b1;
    run_frame(vs, ac, tot, top);
    chk("R7", "new sync applied", vs, 3);
    chk("R7", "new active applied", ac, 5);
    chk("R5", "new frame length", tot, f_len(2, 4));

    // R10: largest row count, back-to-back strobes
    max_gap = 0;
    run_frame(vs, ac, tot, top);
    chk("R10", "active lines", ac, 1024);
    chk("R10", "top row", top, 1023);
    chk("R2", "max sync lines", vs, 64);
    chk("R5", "max frame length", tot, f_len(63, 1023));

    // Random phase: random gaps and random mid-frame writes
    max_gap = 3;
    rnd_chg = 1;
    cfg_sync_w = 6'd1;
    cfg_lines = 10'd3;
    for (int f = 0; f < 40; f++) begin
      run_frame(vs, ac, tot, top);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule